// File: doc/BRIEF.md
# Trap Vector Routing Generator

This block decides, at the moment a trap is taken, which privilege level will run the handler. It also computes the handler fetch addresses. It looks at the current hyperprivileged, privileged and error-recovery bits, the current trap level and the trap type. From these it picks one of four outcomes: privileged handler, hyperprivileged handler, error-recovery (RED) handler, or the error condition. It reports that outcome together with the trap type used to index the vector table. It forms the handler PC from the matching base register and also supplies the two sequential addresses that follow it.

Routing follows a fixed priority. The error-recovery state comes first. Next is the trap-level overflow error. Then a trap that would land in privileged mode while the trap level is already above the privileged ceiling is redirected to the hyperprivileged handler under a fixed watchdog type. Last come the normal privilege and trap-type rules. Updating the trap-stack registers and fetching the handler are done by neighbouring logic. With the default parameters the outputs are registered, so they are valid one clock after the inputs.

Top module: `trap_vector_router`

## Requirements
- R1: The caller level is hyperprivileged when the hpriv bit is set, whatever the priv bit says. Otherwise it is privileged when priv is set, and user when neither is set. A hyperprivileged caller is routed to hyperprivileged mode (code 1). User and privileged callers are routed to privileged mode (code 0) unless a later rule overrides that. The other mode codes are 2 for RED and 3 for error.
- R2: RED mode (code 2) is selected when the red bit is set, or when the trap level equals MAX_TL-1 (5 by default). In RED mode the vector trap type is 5 and the PC is 0xFFF0000000 ORed with ((type << 5) & 0xFF), which gives 0xFFF00000A0.
- R3: When RED mode does not apply and the trap level is MAX_TL (6) or higher, the error mode (code 3) is reported. In that case the vector trap type equals the input trap type, and PC, NPC and the following NPC are all zero.
- R4: When the target would be privileged and the trap level is above MAX_PTL (2), the trap goes to hyperprivileged mode with vector trap type 2. A trap level equal to MAX_PTL does not trigger this.
- R5: The hyperprivileged PC is the hyper base with bits 13:0 cleared, ORed with ((vector type << 5) masked to 14 bits).
- R6: The privileged PC is the trap base with bits 14:0 cleared, ORed with ((type << 5) masked to 14 bits). Bit 14 is also set when the incremented trap level is above 1, which means the current level is nonzero.
- R7: Outside error mode, NPC equals PC+4 and the following NPC equals PC+8.
- R8: A trap bound for privileged mode whose type is 384 or greater is sent to hyperprivileged mode instead. Type 383 stays privileged.
- R9: With REG_OUT=1, every output reflects the inputs sampled at the previous rising clock edge. While the synchronous active-low reset is held, every output is zero.
- R10: A set red bit takes priority over the error condition. A caller with both hpriv and priv set is treated as hyperprivileged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_hpriv | input | 1 | Current hyperprivileged bit |
| cur_priv | input | 1 | Current privileged bit |
| cur_red | input | 1 | Current error-recovery state bit |
| cur_tl | input | TLW (3) | Current trap level |
| trap_type | input | TTW (9) | Incoming trap type |
| tba | input | AW (64) | Privileged trap base address |
| htba | input | AW (64) | Hyperprivileged trap base address |
| mode_o | output | 2 | Selected mode: 0 priv, 1 hyper, 2 RED, 3 error |
| vec_tt_o | output | TTW (9) | Trap type used for the vector |
| handler_pc_o | output | AW (64) | Handler PC |
| handler_npc_o | output | AW (64) | Handler NPC |
| handler_nnpc_o | output | AW (64) | Address after the handler NPC |

## Verification
A routing decision taken in the wrong order can send a trap to the wrong level, for example a watchdog or threshold check placed ahead of the RED or error check. At the ports this shows up at once as a wrong mode code and a wrong vector trap type. The PC also moves to a different base region, so three outputs disagree together on the cycle after the stimulus. A slip in a bit mask, such as the nesting bit or the 14-bit offset, affects only the low PC bits. It shows up only for trap types and trap levels that touch those bits, so the vectors include the type boundaries (383 and 384), the trap-level boundaries (MAX_PTL, MAX_TL-1 and MAX_TL) and a nonzero level against a zero level.

// File: rtl/trap_route_pkg.sv
// Shared types for the trap vector router.
// Assumes a two-bit mode code that the neighbouring trap-entry logic decodes.
package trap_route_pkg;

    typedef enum logic [1:0] {
        MODE_PRIV  = 2'd0,
        MODE_HYPER = 2'd1,
        MODE_RED   = 2'd2,
        MODE_ERROR = 2'd3
    } trap_mode_e;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_PRIV  = 2'd1,
        LVL_HYPER = 2'd2
    } priv_lvl_e;

endpackage

// File: rtl/trap_mode_select.sv
// Picks the handler mode and the vector trap type from the privilege bits,
// the trap level and the trap type.
// Assumes MAX_TL fits in TLW bits and MAX_PTL < MAX_TL - 1.
module trap_mode_select
    import trap_route_pkg::*;
#(
    parameter int TLW          = 3,
    parameter int TTW          = 9,
    parameter int MAX_TL       = 6,
    parameter int MAX_PTL      = 2,
    parameter int HV_THRESH    = 384,
    parameter int RED_VEC_TT   = 5,
    parameter int WDOG_VEC_TT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hpriv_i,
    input  logic             priv_i,
    input  logic             red_i,
    input  logic [TLW-1:0]   tl_i,
    input  logic [TTW-1:0]   tt_i,
    output trap_mode_e       mode_o,
    output logic [TTW-1:0]   vec_tt_o,
    output logic             nested_o
);

    localparam logic [TLW-1:0] TL_RED  = TLW'(MAX_TL - 1);
    localparam logic [TLW-1:0] TL_ERR  = TLW'(MAX_TL);
    localparam logic [TLW-1:0] TL_PTL  = TLW'(MAX_PTL);
    localparam logic [TTW-1:0] TT_THR  = TTW'(HV_THRESH);
    localparam logic [TTW-1:0] TT_RED  = TTW'(RED_VEC_TT);
    localparam logic [TTW-1:0] TT_WDOG = TTW'(WDOG_VEC_TT);

    priv_lvl_e cur_lvl;
    logic      next_is_hyper;

    // Classify the caller's privilege level (hpriv dominates priv).
    always_comb begin
        if (hpriv_i)     cur_lvl = LVL_HYPER;
        else if (priv_i) cur_lvl = LVL_PRIV;
        else             cur_lvl = LVL_USER;
    end

    assign next_is_hyper = (cur_lvl == LVL_HYPER);

    // Priority routing: RED, error, watchdog, hyper, then privileged.
    always_comb begin
        if (red_i || (tl_i == TL_RED)) begin
            mode_o   = MODE_RED;
            vec_tt_o = TT_RED;
        end else if (tl_i >= TL_ERR) begin
            mode_o   = MODE_ERROR;
            vec_tt_o = tt_i;
        end else if (!next_is_hyper && (tl_i > TL_PTL)) begin
            mode_o   = MODE_HYPER;
            vec_tt_o = TT_WDOG;
        end else if (next_is_hyper || (tt_i >= TT_THR)) begin
            mode_o   = MODE_HYPER;
            vec_tt_o = tt_i;
        end else begin
            mode_o   = MODE_PRIV;
            vec_tt_o = tt_i;
        end
    end

    // The new trap level is above one exactly when the current level is nonzero.
    assign nested_o = (tl_i != '0);

    // R2
    red_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        red_i |-> (mode_o == MODE_RED && vec_tt_o == TT_RED));

    // R3
    err_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!red_i && tl_i >= TL_ERR) |-> (mode_o == MODE_ERROR));

    // R1
    hyper_caller_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hpriv_i && !red_i && tl_i < TL_RED) |-> (mode_o == MODE_HYPER && vec_tt_o == tt_i));

    // R4
    hyper_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_HYPER && !hpriv_i) |-> (tl_i > TL_PTL || tt_i >= TT_THR));

endmodule

// File: rtl/trap_vector_calc.sv
// Forms the handler PC for the chosen mode and the two sequential addresses.
// Assumes AW >= 40 so the RED base fits and TTW + 5 <= 14.
module trap_vector_calc
    import trap_route_pkg::*;
#(
    parameter int             AW       = 64,
    parameter int             TTW      = 9,
    parameter logic [AW-1:0]  RED_BASE = '0,
    parameter int             INST_B   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  trap_mode_e       mode_i,
    input  logic [TTW-1:0]   vec_tt_i,
    input  logic             nested_i,
    input  logic [AW-1:0]    tba_i,
    input  logic [AW-1:0]    htba_i,
    output logic [AW-1:0]    pc_o,
    output logic [AW-1:0]    npc_o,
    output logic [AW-1:0]    nnpc_o
);

    localparam logic [AW-1:0] LOW8   = AW'(8'hFF);
    localparam logic [AW-1:0] LOW14  = AW'(16'h3FFF);
    localparam logic [AW-1:0] LOW15  = AW'(16'h7FFF);
    localparam logic [AW-1:0] BIT14  = AW'(16'h4000);
    localparam logic [AW-1:0] STEP1  = AW'(INST_B);
    localparam logic [AW-1:0] STEP2  = AW'(2 * INST_B);

    logic [AW-1:0] tt_shift;
    logic [AW-1:0] red_pc, hyper_pc, priv_pc;

    // Trap type scaled to a 32-byte handler slot.
    assign tt_shift = AW'(vec_tt_i) << 5;

    // Three candidate vectors, one per handler region.
    always_comb begin
        red_pc   = RED_BASE | (tt_shift & LOW8);
        hyper_pc = (htba_i & ~LOW14) | (tt_shift & LOW14);
        priv_pc  = (tba_i & ~LOW15) | (nested_i ? BIT14 : '0) | (tt_shift & LOW14);
    end

    // Select the vector for the chosen mode; error mode yields zeros.
    always_comb begin
        unique case (mode_i)
            MODE_RED:   pc_o = red_pc;
            MODE_HYPER: pc_o = hyper_pc;
            MODE_PRIV:  pc_o = priv_pc;
            default:    pc_o = '0;
        endcase
    end

    // Sequential fetch addresses following the handler entry.
    always_comb begin
        if (mode_i == MODE_ERROR) begin
            npc_o  = '0;
            nnpc_o = '0;
        end else begin
            npc_o  = pc_o + STEP1;
            nnpc_o = pc_o + STEP2;
        end
    end

    // R7
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_ERROR) |-> (npc_o - pc_o == STEP1 && nnpc_o - npc_o == STEP1));

    // R5
    hyper_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_HYPER) |-> (pc_o[AW-1:14] == htba_i[AW-1:14] && pc_o[4:0] == 5'd0));

    // R6
    priv_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PRIV) |-> (pc_o[14] == nested_i && pc_o[AW-1:15] == tba_i[AW-1:15]));

endmodule

// File: rtl/trap_out_stage.sv
// Optional output register: REG_OUT=1 adds one cycle of latency with a
// synchronous active-low reset to zero, REG_OUT=0 passes straight through.
module trap_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] q_r;

            // Capture the routing result every cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d_i;
            end

            assign q_o = q_r;

            // R9
            reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (q_o == $past(d_i)));
        end else begin : g_comb
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/trap_vector_router.sv
// Top of the trap vector router: mode selection, vector formation and an
// optional output register. Assumes trap-level and type widths that match the
// trap-entry logic around it.
module trap_vector_router
    import trap_route_pkg::*;
#(
    parameter int             AW        = 64,
    parameter int             TLW       = 3,
    parameter int             TTW       = 9,
    parameter int             MAX_TL    = 6,
    parameter int             MAX_PTL   = 2,
    parameter int             HV_THRESH = 384,
    parameter logic [AW-1:0]  RED_BASE  = AW'(40'hFF_F000_0000),
    parameter bit             REG_OUT   = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cur_hpriv,
    input  logic            cur_priv,
    input  logic            cur_red,
    input  logic [TLW-1:0]  cur_tl,
    input  logic [TTW-1:0]  trap_type,
    input  logic [AW-1:0]   tba,
    input  logic [AW-1:0]   htba,
    output logic [1:0]      mode_o,
    output logic [TTW-1:0]  vec_tt_o,
    output logic [AW-1:0]   handler_pc_o,
    output logic [AW-1:0]   handler_npc_o,
    output logic [AW-1:0]   handler_nnpc_o
);

    localparam int OUT_W = 2 + TTW + 3 * AW;

    trap_mode_e      sel_mode;
    logic [TTW-1:0]  sel_tt;
    logic            sel_nested;
    logic [AW-1:0]   pc_c, npc_c, nnpc_c;
    logic [OUT_W-1:0] bus_d, bus_q;

    trap_mode_select #(
        .TLW(TLW), .TTW(TTW), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL),
        .HV_THRESH(HV_THRESH), .RED_VEC_TT(5), .WDOG_VEC_TT(2)
    ) u_sel (
        .clk(clk), .rst_n(rst_n),
        .hpriv_i(cur_hpriv), .priv_i(cur_priv), .red_i(cur_red),
        .tl_i(cur_tl), .tt_i(trap_type),
        .mode_o(sel_mode), .vec_tt_o(sel_tt), .nested_o(sel_nested)
    );

    trap_vector_calc #(
        .AW(AW), .TTW(TTW), .RED_BASE(RED_BASE), .INST_B(4)
    ) u_calc (
        .clk(clk), .rst_n(rst_n),
        .mode_i(sel_mode), .vec_tt_i(sel_tt), .nested_i(sel_nested),
        .tba_i(tba), .htba_i(htba),
        .pc_o(pc_c), .npc_o(npc_c), .nnpc_o(nnpc_c)
    );

    assign bus_d = {sel_mode, sel_tt, pc_c, npc_c, nnpc_c};

    trap_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .d_i(bus_d), .q_o(bus_q)
    );

    assign {mode_o, vec_tt_o, handler_pc_o, handler_npc_o, handler_nnpc_o} = bus_q;

endmodule

// File: tb/trap_vector_router_tb.sv
module trap_vector_router_tb;

    typedef struct packed {
        logic        hp;
        logic        pv;
        logic        rd;
        logic [2:0]  tl;
        logic [8:0]  tt;
        logic [1:0]  emode;
        logic [8:0]  ett;
        logic [63:0] epc;
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] TBA_V  = 64'h0000_0000_1234_5678;
    localparam logic [63:0] HTBA_V = 64'hABCD_0000_0009_9999;
    localparam int NV = 14;

    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,3'd0,9'h024,2'd0,9'h024,64'h0000_0000_1234_0480,8'd1},  // R1 user -> priv, tl0
        '{1'b0,1'b1,1'b0,3'd1,9'h010,2'd0,9'h010,64'h0000_0000_1234_4200,8'd6},  // R6 nested bit
        '{1'b1,1'b0,1'b0,3'd1,9'h068,2'd1,9'h068,64'hABCD_0000_0009_8D00,8'd5},  // R5 hyper caller
        '{1'b0,1'b0,1'b0,3'd3,9'h030,2'd1,9'h002,64'hABCD_0000_0009_8040,8'd4},  // R4 watchdog
        '{1'b0,1'b1,1'b0,3'd0,9'h180,2'd1,9'h180,64'hABCD_0000_0009_B000,8'd8},  // R8 type 384
        '{1'b0,1'b1,1'b0,3'd0,9'h17F,2'd0,9'h17F,64'h0000_0000_1234_2FE0,8'd8},  // R8 type 383
        '{1'b0,1'b0,1'b1,3'd0,9'h010,2'd2,9'h005,64'h0000_00FF_F000_00A0,8'd2},  // R2 red bit
        '{1'b1,1'b0,1'b0,3'd5,9'h010,2'd2,9'h005,64'h0000_00FF_F000_00A0,8'd2},  // R2 tl = max-1
        '{1'b0,1'b0,1'b0,3'd6,9'h022,2'd3,9'h022,64'h0,8'd3},                    // R3 tl = max
        '{1'b0,1'b1,1'b1,3'd6,9'h005,2'd2,9'h005,64'h0000_00FF_F000_00A0,8'd10}, // R10 red beats error
        '{1'b0,1'b0,1'b0,3'd7,9'h07F,2'd3,9'h07F,64'h0,8'd3},                    // R3 tl above max
        '{1'b1,1'b1,1'b0,3'd2,9'h010,2'd1,9'h010,64'hABCD_0000_0009_8200,8'd10}, // R10 hpriv wins
        '{1'b0,1'b0,1'b0,3'd2,9'h041,2'd0,9'h041,64'h0000_0000_1234_4820,8'd4},  // R4 tl = max_ptl stays priv
        '{1'b1,1'b0,1'b0,3'd3,9'h010,2'd1,9'h010,64'hABCD_0000_0009_8200,8'd1}   // R1 hyper caller, no watchdog
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp, pv, rd;
    logic [2:0]  tl;
    logic [8:0]  tt;
    logic [1:0]  mode;
    logic [8:0]  vtt;
    logic [63:0] pc, npc, nnpc;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    trap_vector_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .cur_hpriv(hp), .cur_priv(pv), .cur_red(rd),
        .cur_tl(tl), .trap_type(tt), .tba(TBA_V), .htba(HTBA_V),
        .mode_o(mode), .vec_tt_o(vtt),
        .handler_pc_o(pc), .handler_npc_o(npc), .handler_nnpc_o(nnpc)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        hp = v.hp; pv = v.pv; rd = v.rd; tl = v.tl; tt = v.tt;
    endtask

    initial begin
        drive(VECS[2]);
        // R9: outputs held at zero during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset mode", 64'(mode), 64'd0);
        chk("R9 reset pc", pc, 64'd0);
        chk("R9 reset npc", npc, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            drive(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            chk({tag, " mode"}, 64'(mode), 64'(VECS[i].emode));
            chk({tag, " vec_tt"}, 64'(vtt), 64'(VECS[i].ett));
            chk({tag, " pc"}, pc, VECS[i].epc);
            if (VECS[i].emode == 2'd3) begin
                // R3: error mode zeros the follow-on addresses
                chk({tag, " npc R3"}, npc, 64'd0);
                chk({tag, " nnpc R3"}, nnpc, 64'd0);
            end else begin
                // R7: sequential addresses
                chk({tag, " npc R7"}, npc, VECS[i].epc + 64'd4);
                chk({tag, " nnpc R7"}, nnpc, VECS[i].epc + 64'd8);
            end
        end

        // R9: one-cycle latency, old result visible until the next edge
        drive(VECS[0]);
        #1;
        chk("R9 latency hold pc", pc, VECS[NV-1].epc);
        @(posedge clk);
        @(negedge clk);
        chk("R9 latency update pc", pc, VECS[0].epc);

        // R9: reset asserted mid-run clears outputs on the next edge
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 mid-run reset vec_tt", 64'(vtt), 64'd0);
        chk("R9 mid-run reset nnpc", nnpc, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule